// File: doc/BRIEF.md
# I2C Repeated-Start and Stop Request Controller

This block keeps the two software-visible request flags that an I2C master uses to ask for a repeated start or a stop condition. Software writes each flag through its own write strobe and data bit. The block decides whether a write of 1 is accepted and turns an accepted, pending request into a single-cycle issue pulse for the bus sequencer. It also clears each flag when the bus monitor reports the event that ends or cancels the request.

The bus monitor supplies the bus-busy level, the master-mode level and single-cycle events: arbitration lost, start or restart detected, and stop detected. The sequencer supplies two levels that say a stop or a repeated start is being driven onto the bus at that moment. A module-reset event clears both requests. This reset is separate from the synchronous power-on reset. A restart request written while the controller is a slave stays pending, and it is issued as soon as master mode is entered.

Top module: `i2c_cond_req_ctrl`

## Requirements
- R1: After `rst` both flag outputs and both issue outputs are 0.
- R2: A restart write with data 1 sets `rs_flag` only while `bus_busy` is 1. `master` is not needed, and with `bus_busy` at 0 the write has no effect.
- R3: A stop write with data 1 sets `sp_flag` only while `bus_busy` and `master` are both 1. Otherwise the write leaves `sp_flag` unchanged.
- R4: `rs_flag` clears on a restart write with data 0, on `start_det`, on `arb_lost` or on `mod_rst`. It does not clear on `stop_det`.
- R5: `sp_flag` clears on a stop write with data 0, on `stop_det`, on `start_det`, on `arb_lost` or on `mod_rst`.
- R6: When a clearing event and an accepted set write for the same flag occur in one cycle, the flag ends at 0.
- R7: A set flag with `bus_busy` and `master` both 1 produces its issue output high for exactly one cycle. The pulse comes in the cycle after the flag first reads 1 under those conditions. It fires once per request, and a fresh request after a clear fires again.
- R8: A restart request set while `master` is 0 holds `rs_flag` at 1 without an issue pulse. The pulse follows one cycle after `master` becomes 1.
- R9: A restart write of 1 is ignored while `stop_active` is 1, and a stop write of 1 is ignored while `rs_active` is 1.
- R10: After its issue pulse a flag stays at 1 until one of its clearing events occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_rst | input | 1 | Module reset event, clears both requests |
| rs_we | input | 1 | Restart flag write strobe |
| rs_wdata | input | 1 | Restart flag write data |
| sp_we | input | 1 | Stop flag write strobe |
| sp_wdata | input | 1 | Stop flag write data |
| bus_busy | input | 1 | Bus is busy (level) |
| master | input | 1 | Controller is in master mode (level) |
| arb_lost | input | 1 | Arbitration lost event |
| start_det | input | 1 | Start or restart condition detected event |
| stop_det | input | 1 | Stop condition detected event |
| stop_active | input | 1 | Sequencer is issuing a stop |
| rs_active | input | 1 | Sequencer is issuing a repeated start |
| rs_flag | output | 1 | Restart request flag |
| sp_flag | output | 1 | Stop request flag |
| rs_issue | output | 1 | Restart issue pulse to sequencer |
| sp_issue | output | 1 | Stop issue pulse to sequencer |

## Verification
The set writes are tried under every combination of bus-busy and master mode. This shows that the restart flag ignores master mode while the stop flag needs it. Each clearing event is applied on its own to a set flag. Stop-detected is applied to the restart flag to show that the two clear lists differ. Collisions of a write with arbitration loss, and writes made while the opposite condition is in progress, separate the clear-over-set priority from the mutual-exclusion gating. A slave-mode restart followed by entry into master mode shows the deferred pulse, and a second request after a clear shows that the pulse re-arms.

// File: rtl/cond_req_pkg.sv
package cond_req_pkg;

  // Bus monitor and housekeeping events that may end a request.
  typedef struct packed {
    logic mod_rst;
    logic arb_lost;
    logic start_det;
    logic stop_det;
  } bus_evt_t;

  // Which request a flag cell implements; selects gating and clear list.
  typedef enum logic {
    REQ_RESTART = 1'b0,
    REQ_STOP    = 1'b1
  } req_kind_e;

endpackage

// File: rtl/req_flag.sv
module req_flag
  import cond_req_pkg::*;
#(
  parameter req_kind_e KIND = REQ_RESTART
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     we,
  input  logic     wdata,
  input  logic     bus_busy,
  input  logic     master,
  input  logic     opposite_active,
  input  bus_evt_t evt,
  output logic     flag_q,
  output logic     clr
);

  logic gate_ok;
  logic evt_clr;

  generate
    if (KIND == REQ_STOP) begin : g_stop
      // Stop needs master mode to be accepted; also ends on stop or start.
      assign gate_ok = bus_busy & master & ~opposite_active;
      assign evt_clr = evt.mod_rst | evt.arb_lost | evt.stop_det | evt.start_det;
    end else begin : g_restart
      // Restart may be queued from slave mode; ends on the issued start.
      assign gate_ok = bus_busy & ~opposite_active;
      assign evt_clr = evt.mod_rst | evt.arb_lost | evt.start_det;
    end
  endgenerate

  logic set_req;

  always_comb begin
    clr     = evt_clr | (we & ~wdata);
    set_req = we & wdata & gate_ok;
  end

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (clr)     flag_q <= 1'b0;
    else if (set_req) flag_q <= 1'b1;
  end

endmodule

// File: rtl/issue_pulser.sv
module issue_pulser (
  input  logic clk,
  input  logic rst,
  input  logic flag_q,
  input  logic clr,
  input  logic bus_busy,
  input  logic master,
  output logic issue
);

  logic done_q;
  logic fire;

  always_comb fire = flag_q & ~clr & bus_busy & master & ~done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      issue  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      issue <= fire;
      if (clr)       done_q <= 1'b0;
      else if (fire) done_q <= 1'b1;
    end
  end

endmodule

// File: rtl/i2c_cond_req_ctrl.sv
module i2c_cond_req_ctrl
  import cond_req_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mod_rst,
  input  logic rs_we,
  input  logic rs_wdata,
  input  logic sp_we,
  input  logic sp_wdata,
  input  logic bus_busy,
  input  logic master,
  input  logic arb_lost,
  input  logic start_det,
  input  logic stop_det,
  input  logic stop_active,
  input  logic rs_active,
  output logic rs_flag,
  output logic sp_flag,
  output logic rs_issue,
  output logic sp_issue
);

  bus_evt_t evt;
  logic     rs_clr;
  logic     sp_clr;

  always_comb begin
    evt.mod_rst   = mod_rst;
    evt.arb_lost  = arb_lost;
    evt.start_det = start_det;
    evt.stop_det  = stop_det;
  end

  req_flag #(.KIND(REQ_RESTART)) u_rs_flag (
    .clk(clk), .rst(rst), .we(rs_we), .wdata(rs_wdata),
    .bus_busy(bus_busy), .master(master), .opposite_active(stop_active),
    .evt(evt), .flag_q(rs_flag), .clr(rs_clr)
  );

  req_flag #(.KIND(REQ_STOP)) u_sp_flag (
    .clk(clk), .rst(rst), .we(sp_we), .wdata(sp_wdata),
    .bus_busy(bus_busy), .master(master), .opposite_active(rs_active),
    .evt(evt), .flag_q(sp_flag), .clr(sp_clr)
  );

  issue_pulser u_rs_pulse (
    .clk(clk), .rst(rst), .flag_q(rs_flag), .clr(rs_clr),
    .bus_busy(bus_busy), .master(master), .issue(rs_issue)
  );

  issue_pulser u_sp_pulse (
    .clk(clk), .rst(rst), .flag_q(sp_flag), .clr(sp_clr),
    .bus_busy(bus_busy), .master(master), .issue(sp_issue)
  );

endmodule

// File: rtl/i2c_cond_req_chk.sv
module i2c_cond_req_chk (
  input logic clk,
  input logic rst,
  input logic mod_rst,
  input logic rs_we,
  input logic rs_wdata,
  input logic sp_we,
  input logic sp_wdata,
  input logic bus_busy,
  input logic master,
  input logic arb_lost,
  input logic start_det,
  input logic stop_det,
  input logic stop_active,
  input logic rs_active,
  input logic rs_flag,
  input logic sp_flag,
  input logic rs_issue,
  input logic sp_issue
);

  // R2: restart write while bus idle leaves a clear flag clear
  a_r2_rs_needs_busy: assert property (@(posedge clk) disable iff (rst)
    (rs_we && rs_wdata && !bus_busy && !rs_flag) |=> !rs_flag);

  // R3: stop write outside master mode leaves a clear flag clear
  a_r3_sp_needs_master: assert property (@(posedge clk) disable iff (rst)
    (sp_we && sp_wdata && !master && !sp_flag) |=> !sp_flag);

  // R4 / R5: arbitration loss or module reset drops both requests
  a_r5_cancel_both: assert property (@(posedge clk) disable iff (rst)
    (arb_lost || mod_rst) |=> (!rs_flag && !sp_flag && !rs_issue && !sp_issue));

  // R6: clear wins over a simultaneous set
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (rs_we && rs_wdata && start_det) |=> !rs_flag);

  // R7: issue pulses last one cycle and follow a pending flag in master mode
  a_r7_rs_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rs_issue |=> !rs_issue);
  a_r7_sp_one_cycle: assert property (@(posedge clk) disable iff (rst)
    sp_issue |=> !sp_issue);
  a_r7_rs_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(rs_issue) |-> ($past(rs_flag) && $past(master) && $past(bus_busy)));

  // R9: mutual exclusion of set writes
  a_r9_rs_blocked: assert property (@(posedge clk) disable iff (rst)
    (rs_we && rs_wdata && stop_active && !rs_flag) |=> !rs_flag);
  a_r9_sp_blocked: assert property (@(posedge clk) disable iff (rst)
    (sp_we && sp_wdata && rs_active && !sp_flag) |=> !sp_flag);

  // R10: a flag does not drop without one of its clearing events
  a_r10_rs_holds: assert property (@(posedge clk) disable iff (rst)
    (rs_flag && !mod_rst && !arb_lost && !start_det && !(rs_we && !rs_wdata))
      |=> rs_flag);

endmodule

bind i2c_cond_req_ctrl i2c_cond_req_chk u_chk (
  .clk(clk), .rst(rst), .mod_rst(mod_rst), .rs_we(rs_we), .rs_wdata(rs_wdata),
  .sp_we(sp_we), .sp_wdata(sp_wdata), .bus_busy(bus_busy), .master(master),
  .arb_lost(arb_lost), .start_det(start_det), .stop_det(stop_det),
  .stop_active(stop_active), .rs_active(rs_active), .rs_flag(rs_flag),
  .sp_flag(sp_flag), .rs_issue(rs_issue), .sp_issue(sp_issue)
);

// File: tb/sim_i2c_cond_req_ctrl.sv
module sim_i2c_cond_req_ctrl;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mod_rst = 0, rs_we = 0, rs_wdata = 0, sp_we = 0, sp_wdata = 0;
  logic bus_busy = 0, master = 0, arb_lost = 0, start_det = 0, stop_det = 0;
  logic stop_active = 0, rs_active = 0;
  logic rs_flag, sp_flag, rs_issue, sp_issue;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cond_req_ctrl u0 (
    .clk(clk), .rst(rst), .mod_rst(mod_rst), .rs_we(rs_we), .rs_wdata(rs_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .bus_busy(bus_busy), .master(master),
    .arb_lost(arb_lost), .start_det(start_det), .stop_det(stop_det),
    .stop_active(stop_active), .rs_active(rs_active), .rs_flag(rs_flag),
    .sp_flag(sp_flag), .rs_issue(rs_issue), .sp_issue(sp_issue)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic wr_rs(logic d);
    rs_we = 1; rs_wdata = d; step(); rs_we = 0; rs_wdata = 0;
  endtask

  task automatic wr_sp(logic d);
    sp_we = 1; sp_wdata = d; step(); sp_we = 0; sp_wdata = 0;
  endtask

  task automatic pulse_evt(ref logic s);
    s = 1; step(); s = 0;
  endtask

  task automatic clean();
    mod_rst = 1; step(); mod_rst = 0; step();
  endtask

  task automatic t_reset();
    check("R1", "rs_flag", rs_flag, 0);
    check("R1", "sp_flag", sp_flag, 0);
    check("R1", "rs_issue", rs_issue, 0);
    check("R1", "sp_issue", sp_issue, 0);
  endtask

  task automatic t_set_gating();
    bus_busy = 0; master = 1; wr_rs(1);
    check("R2", "rs idle bus", rs_flag, 0);
    bus_busy = 1; master = 0; wr_rs(1);
    check("R2", "rs slave busy", rs_flag, 1);
    clean();
    bus_busy = 0; master = 1; wr_sp(1);
    check("R3", "sp idle bus", sp_flag, 0);
    bus_busy = 1; master = 0; wr_sp(1);
    check("R3", "sp slave", sp_flag, 0);
    bus_busy = 1; master = 1; wr_sp(1);
    check("R3", "sp master busy", sp_flag, 1);
    clean();
  endtask

  task automatic t_pulse();
    bus_busy = 1; master = 1; wr_rs(1);
    check("R7", "rs flag set", rs_flag, 1);
    check("R7", "rs no pulse yet", rs_issue, 0);
    step();
    check("R7", "rs pulse", rs_issue, 1);
    step();
    check("R7", "rs pulse ends", rs_issue, 0);
    check("R10", "rs held", rs_flag, 1);
    step(); step();
    check("R7", "rs no repeat", rs_issue, 0);
    check("R10", "rs still held", rs_flag, 1);
    wr_rs(0);
    check("R4", "rs write0", rs_flag, 0);
    wr_rs(1); step();
    check("R7", "rs re-armed", rs_issue, 1);
    wr_sp(1); step();
    check("R7", "sp pulse", sp_issue, 1);
    step();
    check("R7", "sp pulse ends", sp_issue, 0);
    check("R10", "sp held", sp_flag, 1);
    clean();
  endtask

  task automatic t_rs_clears();
    bus_busy = 1; master = 1;
    wr_rs(1); pulse_evt(stop_det);
    check("R4", "rs ignores stop_det", rs_flag, 1);
    pulse_evt(start_det);
    check("R4", "rs start_det", rs_flag, 0);
    wr_rs(1); pulse_evt(arb_lost);
    check("R4", "rs arb_lost", rs_flag, 0);
    wr_rs(1); pulse_evt(mod_rst);
    check("R4", "rs mod_rst", rs_flag, 0);
    clean();
  endtask

  task automatic t_sp_clears();
    bus_busy = 1; master = 1;
    wr_sp(1); wr_sp(0);
    check("R5", "sp write0", sp_flag, 0);
    wr_sp(1); pulse_evt(stop_det);
    check("R5", "sp stop_det", sp_flag, 0);
    wr_sp(1); pulse_evt(start_det);
    check("R5", "sp start_det", sp_flag, 0);
    wr_sp(1); pulse_evt(arb_lost);
    check("R5", "sp arb_lost", sp_flag, 0);
    wr_sp(1); pulse_evt(mod_rst);
    check("R5", "sp mod_rst", sp_flag, 0);
    clean();
  endtask

  task automatic t_clear_priority();
    bus_busy = 1; master = 1;
    rs_we = 1; rs_wdata = 1; arb_lost = 1;
    sp_we = 1; sp_wdata = 1;
    step();
    rs_we = 0; rs_wdata = 0; arb_lost = 0; sp_we = 0; sp_wdata = 0;
    check("R6", "rs vs arb_lost", rs_flag, 0);
    check("R6", "sp vs arb_lost", sp_flag, 0);
    step();
    check("R6", "no rs pulse", rs_issue, 0);
    check("R6", "no sp pulse", sp_issue, 0);
    clean();
  endtask

  task automatic t_slave_pending();
    bus_busy = 1; master = 0; wr_rs(1);
    step(); step();
    check("R8", "pending flag", rs_flag, 1);
    check("R8", "no slave pulse", rs_issue, 0);
    master = 1; step();
    check("R8", "pulse after master", rs_issue, 1);
    step();
    check("R8", "pulse ends", rs_issue, 0);
    clean();
  endtask

  task automatic t_mutex();
    bus_busy = 1; master = 1;
    stop_active = 1; wr_rs(1); stop_active = 0;
    check("R9", "rs blocked by stop", rs_flag, 0);
    rs_active = 1; wr_sp(1); rs_active = 0;
    check("R9", "sp blocked by restart", sp_flag, 0);
    rs_active = 1; wr_rs(1); rs_active = 0;
    check("R9", "rs not blocked by own", rs_flag, 1);
    clean();
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    t_reset();
    t_set_gating();
    t_pulse();
    t_rs_clears();
    t_sp_clears();
    t_clear_priority();
    t_slave_pending();
    t_mutex();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule